// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Cache

This block lets a cache keep serving the pipeline while several block misses are in flight. Each miss from the load/store pipeline names a block address, the cache set index the block will fill, the word inside the block, and either a destination register (load) or a data word (store). A miss to a block that is not yet tracked takes a free tracking entry and sends a memory request carrying that entry's number. A miss to a block that is already tracked joins the existing entry and does not send a second request.

Memory answers with the entry number and the whole block, in any order. In the cycle a response arrives, the block goes out to the cache with the waiting store words laid over it. Every word that a load is waiting on is sent out on its own forwarding lane, so the register file can be written in the same cycle. The entry is then free from the next cycle.

A miss that cannot be taken is held off with a stall signal. This happens when the table is full, when the miss would collide with a word already waiting, or when it targets an entry whose response arrives in that same cycle.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is tracked: with no miss and no response offered, `miss_stall`, `mem_req_valid`, `cache_wr_valid` and all `fwd_valid` lanes are 0, and the first primary miss takes entry 0.
- R2: A miss whose block matches no tracked entry, while an entry is free, is accepted in the same cycle. It takes the lowest-numbered free entry and raises `mem_req_valid` with `mem_req_addr` equal to the block address and `mem_req_id` equal to that entry number.
- R3: A miss whose block matches a tracked entry is accepted without stall and without a memory request (secondary miss), unless R5 or R10 applies.
- R4: A primary miss while all entries are tracked raises `miss_stall` and issues no memory request.
- R5: A secondary load stalls if its word already has a waiting load or a waiting store. A secondary store stalls if its word already has a waiting store. A secondary store to a word with only a waiting load merges.
- R6: A response whose `fill_id` names a tracked entry raises `cache_wr_valid` in the same cycle. It carries that entry's set index and block address, and the line has each word with a waiting store replaced by the store data; word w sits at bits [w*DATA_W +: DATA_W].
- R7: In the same cycle as R6, lane w of `fwd_valid` is 1 exactly when a load waits on word w. `fwd_reg` lane w (bits [w*REG_W +: REG_W]) is that load's register and `fwd_data` lane w is word w of the returned memory data, not the store data.
- R8: Responses may come back in any order; the entry named by a response is free from the next cycle and can be taken again by a later primary miss.
- R9: A response naming an entry that is not tracked is ignored: no cache write and no forward.
- R10: A miss to the block of the entry whose response arrives in the same cycle stalls.
- R11: A stalled miss changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is offered this cycle |
| miss_is_store | input | 1 | 1 for a store miss, 0 for a load miss |
| miss_blk_addr | input | ADDR_W | Block address of the miss |
| miss_index | input | IDX_W | Cache set index the block will fill |
| miss_word | input | OFF_W | Word within the block |
| miss_reg | input | REG_W | Destination register of a load |
| miss_wdata | input | DATA_W | Data word of a store |
| miss_stall | output | 1 | The offered miss is not taken this cycle |
| mem_req_valid | output | 1 | Memory request for a newly tracked block |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_req_id | output | ID_W | Entry number the response must carry |
| fill_valid | input | 1 | Memory response this cycle |
| fill_id | input | ID_W | Entry number of the response |
| fill_data | input | WORDS*DATA_W | Returned block, word w at [w*DATA_W +: DATA_W] |
| cache_wr_valid | output | 1 | Write the merged line into the cache |
| cache_wr_index | output | IDX_W | Set index for the cache write |
| cache_wr_blk | output | ADDR_W | Block address for the cache write |
| cache_wr_data | output | WORDS*DATA_W | Merged line |
| fwd_valid | output | WORDS | Per-word forward strobe |
| fwd_reg | output | WORDS*REG_W | Per-word destination register |
| fwd_data | output | WORDS*DATA_W | Per-word forwarded data |

## Verification
The hardest situations to reach are those that need a particular set of entries already tracked. These are a full table, a word holding both a waiting load and a waiting store, and a response arriving for one entry while a miss targets that same entry. The stimulus builds them step by step: it fills every entry, then piles secondary misses onto one block, and then offers responses out of allocation order. Some of those responses are paired in one cycle with a miss to the block being filled, or with a fresh primary miss. A model of the entries in the bench predicts every stall, request, line and forward, and a scoreboard compares them in arrival order.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    // What happens to the offered miss in the current cycle
    typedef enum logic [1:0] {
        MR_IDLE  = 2'd0,
        MR_STALL = 2'd1,
        MR_MERGE = 2'd2,
        MR_ALLOC = 2'd3
    } miss_act_e;

endpackage

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 26,
    parameter int ID_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_ENT-1:0]              busy,
    input  logic [N_ENT-1:0][ADDR_W-1:0]  tags,
    input  logic [ADDR_W-1:0]             probe,
    output logic                          hit,
    output logic [ID_W-1:0]               hit_id,
    output logic                          free_any,
    output logic [ID_W-1:0]               free_id
);

    logic [N_ENT-1:0] hit_vec;

    // one comparator per entry
    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign hit_vec[e] = busy[e] && (tags[e] == probe);
    end

    always_comb begin
        hit      = |hit_vec;
        free_any = ~&busy;
        hit_id   = '0;
        free_id  = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (hit_vec[e]) hit_id  = ID_W'(e);
            if (!busy[e])   free_id = ID_W'(e);
        end
    end

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/mshr_fill_merge.sv
module mshr_fill_merge #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input  logic                           take,
    input  logic [WORDS-1:0][DATA_W-1:0]   mem_data,
    input  logic [WORDS-1:0]               st_vld,
    input  logic [WORDS-1:0][DATA_W-1:0]   st_data,
    input  logic [WORDS-1:0]               ld_vld,
    input  logic [WORDS-1:0][REG_W-1:0]    ld_reg,
    output logic [WORDS-1:0][DATA_W-1:0]   line_data,
    output logic [WORDS-1:0]               fwd_vld,
    output logic [WORDS-1:0][REG_W-1:0]    fwd_reg,
    output logic [WORDS-1:0][DATA_W-1:0]   fwd_data
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign line_data[w] = st_vld[w] ? st_data[w] : mem_data[w];
        assign fwd_vld[w]   = take && ld_vld[w];
        assign fwd_reg[w]   = ld_reg[w];
        assign fwd_data[w]  = mem_data[w];
    end

endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int WORDS  = 4,
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 6,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int ID_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     miss_valid,
    input  logic                     miss_is_store,
    input  logic [ADDR_W-1:0]        miss_blk_addr,
    input  logic [IDX_W-1:0]         miss_index,
    input  logic [OFF_W-1:0]         miss_word,
    input  logic [REG_W-1:0]         miss_reg,
    input  logic [DATA_W-1:0]        miss_wdata,
    output logic                     miss_stall,
    output logic                     mem_req_valid,
    output logic [ADDR_W-1:0]        mem_req_addr,
    output logic [ID_W-1:0]          mem_req_id,
    input  logic                     fill_valid,
    input  logic [ID_W-1:0]          fill_id,
    input  logic [WORDS*DATA_W-1:0]  fill_data,
    output logic                     cache_wr_valid,
    output logic [IDX_W-1:0]         cache_wr_index,
    output logic [ADDR_W-1:0]        cache_wr_blk,
    output logic [WORDS*DATA_W-1:0]  cache_wr_data,
    output logic [WORDS-1:0]         fwd_valid,
    output logic [WORDS*REG_W-1:0]   fwd_reg,
    output logic [WORDS*DATA_W-1:0]  fwd_data
);

    typedef struct packed {
        logic [N_ENT-1:0]                          busy;
        logic [N_ENT-1:0][ADDR_W-1:0]              blk;
        logic [N_ENT-1:0][IDX_W-1:0]               idx;
        logic [N_ENT-1:0][WORDS-1:0]               ldv;
        logic [N_ENT-1:0][WORDS-1:0][REG_W-1:0]    ldreg;
        logic [N_ENT-1:0][WORDS-1:0]               stv;
        logic [N_ENT-1:0][WORDS-1:0][DATA_W-1:0]   stdat;
    } tbl_t;

    tbl_t        tbl_d, tbl_q;
    miss_act_e   act;
    logic        hit, free_any, fill_take, word_clash;
    logic [ID_W-1:0] hit_id, free_id, tgt;

    logic [WORDS-1:0][DATA_W-1:0] mem_words, line_words, fwd_words;
    logic [WORDS-1:0][REG_W-1:0]  fwd_regs;

    assign mem_words = fill_data;

    mshr_lookup #(
        .N_ENT (N_ENT),
        .ADDR_W(ADDR_W),
        .ID_W  (ID_W)
    ) u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (tbl_q.busy),
        .tags    (tbl_q.blk),
        .probe   (miss_blk_addr),
        .hit     (hit),
        .hit_id  (hit_id),
        .free_any(free_any),
        .free_id (free_id)
    );

    mshr_fill_merge #(
        .WORDS (WORDS),
        .DATA_W(DATA_W),
        .REG_W (REG_W)
    ) u_merge (
        .take     (fill_take),
        .mem_data (mem_words),
        .st_vld   (tbl_q.stv[fill_id]),
        .st_data  (tbl_q.stdat[fill_id]),
        .ld_vld   (tbl_q.ldv[fill_id]),
        .ld_reg   (tbl_q.ldreg[fill_id]),
        .line_data(line_words),
        .fwd_vld  (fwd_valid),
        .fwd_reg  (fwd_regs),
        .fwd_data (fwd_words)
    );

    always_comb begin
        tbl_d     = tbl_q;
        fill_take = fill_valid && tbl_q.busy[fill_id];
        word_clash = miss_is_store ? tbl_q.stv[hit_id][miss_word]
                                   : (tbl_q.stv[hit_id][miss_word] ||
                                      tbl_q.ldv[hit_id][miss_word]);
        act = MR_IDLE;
        if (miss_valid) begin
            if (hit) begin
                if ((fill_take && (fill_id == hit_id)) || word_clash)
                    act = MR_STALL;
                else
                    act = MR_MERGE;
            end else if (free_any) begin
                act = MR_ALLOC;
            end else begin
                act = MR_STALL;
            end
        end
        tgt = (act == MR_ALLOC) ? free_id : hit_id;

        // response retires its entry
        if (fill_take) begin
            tbl_d.busy[fill_id] = 1'b0;
            tbl_d.ldv[fill_id]  = '0;
            tbl_d.stv[fill_id]  = '0;
        end

        if (act == MR_ALLOC) begin
            tbl_d.busy[tgt] = 1'b1;
            tbl_d.blk[tgt]  = miss_blk_addr;
            tbl_d.idx[tgt]  = miss_index;
            tbl_d.ldv[tgt]  = '0;
            tbl_d.stv[tgt]  = '0;
        end

        if ((act == MR_ALLOC) || (act == MR_MERGE)) begin
            if (miss_is_store) begin
                tbl_d.stv[tgt][miss_word]   = 1'b1;
                tbl_d.stdat[tgt][miss_word] = miss_wdata;
            end else begin
                tbl_d.ldv[tgt][miss_word]   = 1'b1;
                tbl_d.ldreg[tgt][miss_word] = miss_reg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign miss_stall     = (act == MR_STALL);
    assign mem_req_valid  = (act == MR_ALLOC);
    assign mem_req_addr   = miss_blk_addr;
    assign mem_req_id     = free_id;
    assign cache_wr_valid = fill_take;
    assign cache_wr_index = tbl_q.idx[fill_id];
    assign cache_wr_blk   = tbl_q.blk[fill_id];
    assign cache_wr_data  = line_words;
    assign fwd_reg        = fwd_regs;
    assign fwd_data       = fwd_words;

    // R2
    alloc_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> tbl_q.busy[$past(mem_req_id)]);

    // R4
    full_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&tbl_q.busy) |-> !mem_req_valid);

    // R7
    fwd_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid != '0) |-> cache_wr_valid);

    // R8
    fill_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_valid |=> !tbl_q.busy[$past(fill_id)]);

    // R9
    stray_fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !tbl_q.busy[fill_id]) |-> (!cache_wr_valid && fwd_valid == '0));

    // R11
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_stall && !fill_valid) |=> (tbl_q == $past(tbl_q)));

endmodule

// File: tb/sim_mshr_file.sv
`timescale 1ns/1ps
module sim_mshr_file;

    localparam int N  = 4;
    localparam int WD = 4;
    localparam int AW = 26;
    localparam int IW = 6;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              miss_valid = 0, miss_is_store = 0;
    logic [AW-1:0]     miss_blk_addr = '0;
    logic [IW-1:0]     miss_index = '0;
    logic [1:0]        miss_word = '0;
    logic [RW-1:0]     miss_reg = '0;
    logic [DW-1:0]     miss_wdata = '0;
    logic              miss_stall, mem_req_valid;
    logic [AW-1:0]     mem_req_addr;
    logic [1:0]        mem_req_id;
    logic              fill_valid = 0;
    logic [1:0]        fill_id = '0;
    logic [WD*DW-1:0]  fill_data = '0;
    logic              cache_wr_valid;
    logic [IW-1:0]     cache_wr_index;
    logic [AW-1:0]     cache_wr_blk;
    logic [WD*DW-1:0]  cache_wr_data;
    logic [WD-1:0]     fwd_valid;
    logic [WD*RW-1:0]  fwd_reg;
    logic [WD*DW-1:0]  fwd_data;

    mshr_file u0 (.*);

    int checks = 0, fails = 0;
    bit done = 0;
    string tag = "R1";

    // scoreboard queues
    logic [AW+2-1:0]         q_req[$];
    logic [IW+AW+WD*DW-1:0]  q_wr[$];
    logic [RW+DW-1:0]        q_fwd[$];

    // bench model of the entries
    bit          m_busy[N];
    logic [AW-1:0] m_blk[N];
    logic [IW-1:0] m_idx[N];
    bit          m_ldv[N][WD];
    logic [RW-1:0] m_ldr[N][WD];
    bit          m_stv[N][WD];
    logic [DW-1:0] m_std[N][WD];

    function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a, int w);
        return {a, 4'h0, 2'(w)};
    endfunction

    task automatic chk(bit ok, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: compare produced items with the expected queues
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_req_valid) begin
                if (q_req.size() == 0) chk(0, "unexpected mem_req", {mem_req_addr, mem_req_id}, 0);
                else begin
                    logic [AW+1:0] e;
                    e = q_req.pop_front();
                    chk({mem_req_addr, mem_req_id} == e, "R2 mem_req addr/id", {mem_req_addr, mem_req_id}, e);
                end
            end
            if (cache_wr_valid) begin
                if (q_wr.size() == 0) chk(0, "R9 unexpected cache write", cache_wr_data, 0);
                else begin
                    logic [IW+AW+WD*DW-1:0] e;
                    e = q_wr.pop_front();
                    chk({cache_wr_index, cache_wr_blk, cache_wr_data} == e, "R6 cache line",
                        {cache_wr_index, cache_wr_blk, cache_wr_data}, e);
                end
            end
            for (int w = 0; w < WD; w++) begin
                if (fwd_valid[w]) begin
                    if (q_fwd.size() == 0) chk(0, "R7 unexpected forward", w, 0);
                    else begin
                        logic [RW+DW-1:0] e;
                        e = q_fwd.pop_front();
                        chk({fwd_reg[w*RW +: RW], fwd_data[w*DW +: DW]} == e, "R7 forward lane",
                            {fwd_reg[w*RW +: RW], fwd_data[w*DW +: DW]}, e);
                    end
                end
            end
        end
    end

    // driver: one cycle of stimulus, expectations from the model
    task automatic cyc(bit mv, bit st, logic [AW-1:0] a, logic [IW-1:0] ix, int wd,
                       logic [RW-1:0] rg, logic [DW-1:0] wdat, bit fv, int fid);
        bit hit = 0, stall = 0, alloc = 0, take;
        int hid = 0, fr = -1;
        logic [WD*DW-1:0] fd, line;
        logic [WD-1:0] fexp = '0;
        for (int i = 0; i < N; i++)
            if (m_busy[i] && m_blk[i] == a) begin hit = 1; hid = i; end
        for (int i = N - 1; i >= 0; i--)
            if (!m_busy[i]) fr = i;
        take = fv && m_busy[fid];
        if (mv) begin
            if (hit) begin
                if (take && fid == hid) stall = 1;
                else if (st && m_stv[hid][wd]) stall = 1;
                else if (!st && (m_stv[hid][wd] || m_ldv[hid][wd])) stall = 1;
            end else if (fr < 0) stall = 1;
            else alloc = 1;
        end
        for (int w = 0; w < WD; w++) fd[w*DW +: DW] = mem_word(fv ? m_blk[fid] : '0, w);
        if (take) begin
            for (int w = 0; w < WD; w++) begin
                line[w*DW +: DW] = m_stv[fid][w] ? m_std[fid][w] : fd[w*DW +: DW];
                if (m_ldv[fid][w]) begin
                    fexp[w] = 1;
                    q_fwd.push_back({m_ldr[fid][w], fd[w*DW +: DW]});
                end
            end
            q_wr.push_back({m_idx[fid], m_blk[fid], line});
        end
        if (alloc) q_req.push_back({a, 2'(fr)});

        @(posedge clk); #1;
        miss_valid = mv; miss_is_store = st; miss_blk_addr = a; miss_index = ix;
        miss_word = 2'(wd); miss_reg = rg; miss_wdata = wdat;
        fill_valid = fv; fill_id = 2'(fid); fill_data = fd;
        @(negedge clk);
        chk(miss_stall == stall, "miss_stall", miss_stall, stall);
        chk(mem_req_valid == alloc, "mem_req_valid", mem_req_valid, alloc);
        chk(cache_wr_valid == take, "cache_wr_valid", cache_wr_valid, take);
        chk(fwd_valid == fexp, "fwd_valid mask", fwd_valid, fexp);

        if (take) begin
            m_busy[fid] = 0;
            for (int w = 0; w < WD; w++) begin m_ldv[fid][w] = 0; m_stv[fid][w] = 0; end
        end
        if (mv && !stall) begin
            int t = alloc ? fr : hid;
            if (alloc) begin
                m_busy[t] = 1; m_blk[t] = a; m_idx[t] = ix;
                for (int w = 0; w < WD; w++) begin m_ldv[t][w] = 0; m_stv[t][w] = 0; end
            end
            if (st) begin m_stv[t][wd] = 1; m_std[t][wd] = wdat; end
            else    begin m_ldv[t][wd] = 1; m_ldr[t][wd] = rg; end
        end
    endtask

    task automatic ld(logic [AW-1:0] a, logic [IW-1:0] ix, int wd, logic [RW-1:0] rg);
        cyc(1, 0, a, ix, wd, rg, '0, 0, 0);
    endtask
    task automatic sto(logic [AW-1:0] a, logic [IW-1:0] ix, int wd, logic [DW-1:0] d);
        cyc(1, 1, a, ix, wd, '0, d, 0, 0);
    endtask
    task automatic fil(int id);
        cyc(0, 0, '0, '0, 0, '0, '0, 1, id);
    endtask
    task automatic idle();
        cyc(0, 0, '0, '0, 0, '0, '0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) m_busy[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: idle outputs after reset
        tag = "R1";
        idle();
        idle();
        // R1 / R2: first primary misses take entries 0,1,2
        tag = "R2";
        ld (26'h0001A0, 6'd3, 1, 5'd3);
        sto(26'h0001A1, 6'd4, 2, 32'h5555_0001);
        ld (26'h0001A2, 6'd5, 0, 5'd9);
        // R3: secondary merges
        tag = "R3";
        ld (26'h0001A0, 6'd3, 2, 5'd7);
        sto(26'h0001A0, 6'd3, 3, 32'h5555_0003);
        // R5: store over a waiting load merges
        tag = "R5";
        sto(26'h0001A0, 6'd3, 1, 32'h5555_0011);
        // R5: clashes stall
        ld (26'h0001A0, 6'd3, 1, 5'd12);
        sto(26'h0001A0, 6'd3, 3, 32'h6666_0000);
        ld (26'h0001A1, 6'd4, 2, 5'd13);
        ld (26'h0001A0, 6'd3, 3, 5'd14);
        // R4: full table
        tag = "R4";
        ld (26'h0001A3, 6'd6, 3, 5'd20);
        ld (26'h0001A4, 6'd7, 0, 5'd21);
        // R11: stalled miss left entries alone, block A4 still untracked
        tag = "R11";
        sto(26'h0001A4, 6'd7, 1, 32'h7777_0000);
        // R10: miss to entry 2 while its response arrives
        tag = "R10";
        cyc(1, 0, 26'h0001A2, 6'd5, 1, 5'd22, '0, 1, 2);
        // R8: out-of-order response for entry 0
        tag = "R8";
        fil(0);
        // R2 / R8: freed entries reused lowest first
        ld (26'h0001A5, 6'd8, 2, 5'd23);
        // R9: response to a free entry ignored
        tag = "R9";
        fil(2);
        // R6 / R7: response for the store-only entry
        tag = "R6";
        fil(1);
        // R7: response with primary miss in the same cycle
        tag = "R7";
        cyc(1, 0, 26'h0001A6, 6'd9, 3, 5'd24, '0, 1, 3);
        ld (26'h0001A6, 6'd9, 0, 5'd25);
        sto(26'h0001A6, 6'd9, 2, 32'h8888_0002);
        fil(0);
        fil(1);
        // R8: all free again, entry 0 comes back
        tag = "R8";
        ld (26'h0001A7, 6'd10, 1, 5'd26);
        fil(0);
        idle();
        idle();
        tag = "R6";
        chk(q_req.size() == 0 && q_wr.size() == 0 && q_fwd.size() == 0,
            "scoreboard drained", q_req.size() + q_wr.size() + q_fwd.size(), 0);
        finish_run();
    end

endmodule